// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block is the digital sequencer that sits beside a 10-bit analog-to-digital converter. Software programs it through a single control byte. The byte selects one of twelve input channels, chooses single or repeating operation and switches the reference generator. Setting the top bit of the byte starts a conversion. The same bit then reads back as a busy flag until the conversion is over.

The sequencer powers the converter up on demand, adding a wake-up delay when it starts from the off state. It times each conversion in system clocks and stores the 10-bit result across two byte-wide data registers. It pulses an interrupt request when each conversion completes. After a fixed stretch with nothing to do, it turns the converter off again.

The converter's sample arrives on a plain 10-bit input that is captured on the completion edge. The sample has no valid/ready handshake and exerts no back-pressure: it must simply hold steady around the end of each conversion. Register access uses a flat address/write-strobe bus with a combinational read port.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the converter is powered down (`pwr_down_o`=1), `irq_o` is 0, and reads of addresses 0, 1 and 2 all return 0x00.
- R2: The control byte at address 0 has this layout: channel in bits 3..0, continuous mode in bit 4, reference enable in bit 5, bit 6 reading 0, and start/busy in bit 7. `chan_o` and `ref_en_o` follow the stored fields.
- R3: A control write whose channel code is 12 to 15 leaves the stored channel unchanged, but it still updates the other fields. Codes 0 to 11 are stored.
- R4: A start issued while the converter is powered and idle makes bit 7 read 1 on the next cycle. The result is captured on the 5129th clock edge after the write edge.
- R5: A start issued while powered down first spends 40 wake-up cycles, so the result is captured 5169 edges after the write edge. `pwr_down_o` falls on the cycle after the write. A control write without the start bit does not power the converter up.
- R6: The high data register (address 1) holds result bits 9..2. The low data register (address 2) holds result bits 1..0 in its bits 7..6 and reads 0 in bits 5..0. Both data registers change only at a completion.
- R7: In single-shot mode, bit 7 clears on the same edge that raises `irq_o`.
- R8: In continuous mode, conversions follow back to back with no gap. Each one overwrites the data registers and pulses `irq_o`, and bit 7 stays 1 throughout.
- R9: Writing the control byte with bit 7 at 0 during continuous operation lets the conversion in progress finish and report, then stops the sequence.
- R10: Writing bit 7 as 1 while a conversion or wake-up is in progress does not restart it or change its completion time.
- R11: After 160 consecutive idle cycles following a completion, `pwr_down_o` rises. A start that arrives on the 160th idle edge wins and needs no wake-up.
- R12: `irq_o` is high for exactly one cycle per completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register address: 0 control, 1 data high, 2 data low |
| bus_wr | input | 1 | Write strobe for the addressed register (only address 0 is writable) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data of the addressed register |
| sample_in | input | 10 | Converter output, captured at the end of each conversion |
| chan_o | output | 4 | Selected analog channel |
| ref_en_o | output | 1 | Reference generator enable |
| pwr_down_o | output | 1 | High while the converter is powered down |
| irq_o | output | 1 | One-cycle completion interrupt request |

## Verification
On every cycle, the bound checker confirms four things. The busy flag only drops together with an interrupt pulse. Each interrupt ends a busy run whose length is exactly one conversion, or one wake-up plus one conversion. The padding bits of the low data byte stay zero and the data bytes move only on completion. Power state changes only leave the off state into a conversion and only enter it from idle. The bench scenarios cover what depends on register values and on exact timing. These include the channel-code filter, the ignored second start, the boundary between a start on the last idle edge and power-down, the stop request during continuous mode, and the bit placement of randomly chosen samples.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_WAKE = 2'd1,
    ST_IDLE = 2'd2,
    ST_CONV = 2'd3
  } seq_state_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_DHI  = 2'd1;
  localparam logic [1:0] ADDR_DLO  = 2'd2;

  localparam int BIT_CONT  = 4;
  localparam int BIT_REF   = 5;
  localparam int BIT_START = 7;
endpackage

// File: rtl/adc_ctrl_regs.sv
module adc_ctrl_regs #(
  parameter int CH_W   = 4,
  parameter int NUM_CH = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_ctrl,
  input  logic [7:0]      wr_data,
  output logic [CH_W-1:0] chan,
  output logic            cont,
  output logic            ref_en
);
  import adc_seq_pkg::*;

  logic [CH_W-1:0] chan_req;
  logic            chan_ok;

  assign chan_req = wr_data[CH_W-1:0];
  assign chan_ok  = (32'(chan_req) < NUM_CH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chan   <= '0;
      cont   <= 1'b0;
      ref_en <= 1'b0;
    end else if (wr_ctrl) begin
      cont   <= wr_data[BIT_CONT];
      ref_en <= wr_data[BIT_REF];
      if (chan_ok) chan <= chan_req;
    end
  end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm #(
  parameter int CONV_CYCLES = 5129,
  parameter int WAKE_CYCLES = 40,
  parameter int IDLE_CYCLES = 160
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_wr,
  input  logic stop_wr,
  input  logic cont,
  output logic busy,
  output logic pwr_down,
  output logic capture,
  output logic irq
);
  import adc_seq_pkg::*;

  localparam int M1    = (CONV_CYCLES > WAKE_CYCLES) ? CONV_CYCLES : WAKE_CYCLES;
  localparam int MAXC  = (M1 > IDLE_CYCLES) ? M1 : IDLE_CYCLES;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_CYCLES - 1);
  localparam logic [CNT_W-1:0] WAKE_LAST = CNT_W'(WAKE_CYCLES - 1);
  localparam logic [CNT_W-1:0] IDLE_LAST = CNT_W'(IDLE_CYCLES - 1);

  seq_state_t      state, state_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic            stop_pend, stop_pend_n;

  assign busy     = (state == ST_WAKE) || (state == ST_CONV);
  assign pwr_down = (state == ST_OFF);
  assign capture  = (state == ST_CONV) && (cnt == CONV_LAST);

  always_comb begin
    state_n     = state;
    cnt_n       = cnt + 1'b1;
    stop_pend_n = stop_pend | (stop_wr & busy);
    case (state)
      ST_OFF: begin
        cnt_n = '0;
        if (start_wr) state_n = ST_WAKE;
      end
      ST_WAKE: begin
        if (cnt == WAKE_LAST) begin
          state_n = ST_CONV;
          cnt_n   = '0;
        end
      end
      ST_IDLE: begin
        if (start_wr) begin
          state_n = ST_CONV;
          cnt_n   = '0;
        end else if (cnt == IDLE_LAST) begin
          state_n = ST_OFF;
          cnt_n   = '0;
        end
      end
      ST_CONV: begin
        if (capture) begin
          cnt_n = '0;
          if (!cont || stop_pend_n) begin
            state_n     = ST_IDLE;
            stop_pend_n = 1'b0;
          end
        end
      end
      default: begin
        state_n = ST_OFF;
        cnt_n   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_OFF;
      cnt       <= '0;
      stop_pend <= 1'b0;
      irq       <= 1'b0;
    end else begin
      state     <= state_n;
      cnt       <= cnt_n;
      stop_pend <= stop_pend_n;
      irq       <= capture;
    end
  end
endmodule

// File: rtl/adc_result_regs.sv
module adc_result_regs #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [RES_W-1:0] sample,
  output logic [7:0]       res_hi,
  output logic [7:0]       res_lo
);
  localparam int LO_BITS = RES_W - 8;
  localparam int LO_PAD  = 8 - LO_BITS;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_hi <= '0;
      res_lo <= '0;
    end else if (capture) begin
      res_hi <= sample[RES_W-1:LO_BITS];
      res_lo <= {sample[LO_BITS-1:0], {LO_PAD{1'b0}}};
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int CH_W        = 4,
  parameter int NUM_CH      = 12,
  parameter int RES_W       = 10,
  parameter int CONV_CYCLES = 5129,
  parameter int WAKE_CYCLES = 40,
  parameter int IDLE_CYCLES = 160
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic [RES_W-1:0] sample_in,
  output logic [CH_W-1:0]  chan_o,
  output logic             ref_en_o,
  output logic             pwr_down_o,
  output logic             irq_o
);
  import adc_seq_pkg::*;

  logic       wr_ctrl, start_wr, stop_wr;
  logic       cont, busy, capture;
  logic [7:0] res_hi, res_lo;
  logic [7:0] ctrl_view;

  assign wr_ctrl  = bus_wr && (bus_addr == ADDR_CTRL);
  assign start_wr = wr_ctrl && bus_wdata[BIT_START];
  assign stop_wr  = wr_ctrl && !bus_wdata[BIT_START];

  adc_ctrl_regs #(.CH_W(CH_W), .NUM_CH(NUM_CH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_data(bus_wdata),
    .chan(chan_o), .cont(cont), .ref_en(ref_en_o)
  );

  adc_seq_fsm #(
    .CONV_CYCLES(CONV_CYCLES), .WAKE_CYCLES(WAKE_CYCLES), .IDLE_CYCLES(IDLE_CYCLES)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .stop_wr(stop_wr), .cont(cont),
    .busy(busy), .pwr_down(pwr_down_o), .capture(capture), .irq(irq_o)
  );

  adc_result_regs #(.RES_W(RES_W)) u_res (
    .clk(clk), .rst_n(rst_n), .capture(capture), .sample(sample_in),
    .res_hi(res_hi), .res_lo(res_lo)
  );

  always_comb begin
    ctrl_view                = '0;
    ctrl_view[CH_W-1:0]      = chan_o;
    ctrl_view[BIT_CONT]      = cont;
    ctrl_view[BIT_REF]       = ref_en_o;
    ctrl_view[BIT_START]     = busy;
  end

  always_comb begin
    case (bus_addr)
      ADDR_CTRL: bus_rdata = ctrl_view;
      ADDR_DHI:  bus_rdata = res_hi;
      ADDR_DLO:  bus_rdata = res_lo;
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int RES_W       = 10,
  parameter int CONV_CYCLES = 5129,
  parameter int WAKE_CYCLES = 40
) (
  input logic       clk,
  input logic       rst_n,
  input logic       irq,
  input logic       busy,
  input logic       pwr_down,
  input logic [7:0] res_hi,
  input logic [7:0] res_lo
);
  localparam int LO_PAD = 16 - RES_W;

  int unsigned run_len;

  always_ff @(posedge clk) begin
    if (!rst_n)      run_len <= 0;
    else if (irq)    run_len <= busy ? 1 : 0;
    else if (busy)   run_len <= run_len + 1;
    else             run_len <= 0;
  end

  // R7: busy ends only together with a completion pulse
  p_busy_ends_with_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq);

  // R12: the interrupt request never lasts two cycles
  p_irq_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R4: every completion closes a busy run of one conversion, or wake-up plus conversion
  p_conv_length_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (run_len == CONV_CYCLES || run_len == WAKE_CYCLES + CONV_CYCLES));

  // R6: padding bits of the low data byte stay zero
  p_lo_pad_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_lo[LO_PAD-1:0] == '0);

  // R6: data bytes move only at a completion
  p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_hi != $past(res_hi) || res_lo != $past(res_lo)) |-> irq);

  // R5: leaving power-down happens only into a conversion
  p_wake_on_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_down) |-> busy);

  // R11: power-down is entered only from idle
  p_down_from_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_down) |-> (!busy && !$past(busy)));
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(
  .RES_W(RES_W), .CONV_CYCLES(CONV_CYCLES), .WAKE_CYCLES(WAKE_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq_o), .busy(busy), .pwr_down(pwr_down_o),
  .res_hi(res_hi), .res_lo(res_lo)
);

// File: tb/tb_adc_seq_ctrl.sv
`timescale 1ns/1ps
module tb_adc_seq_ctrl;
  localparam int CONV = 5129;
  localparam int WAKE = 40;
  localparam int IDLE = 160;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic [9:0] sample_in = 10'd0;
  logic [3:0] chan_o;
  logic       ref_en_o, pwr_down_o, irq_o;

  int unsigned cyc = 0;
  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  adc_seq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sample_in(sample_in),
    .chan_o(chan_o), .ref_en_o(ref_en_o), .pwr_down_o(pwr_down_o), .irq_o(irq_o)
  );

  function automatic logic [7:0] exp_hi(logic [9:0] s);
    return s[9:2];
  endfunction
  function automatic logic [7:0] exp_lo(logic [9:0] s);
    return {s[1:0], 6'b0};
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic wait_to(int unsigned t);
    while (cyc < t) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] v);
    bus_addr = a;
    #0.1;
    v = bus_rdata;
  endtask

  task automatic wr(logic [7:0] d, output int unsigned e0);
    @(negedge clk);
    bus_addr  = 2'd0;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(posedge clk);
    #1;
    bus_wr = 1'b0;
    e0 = cyc;
  endtask

  // checks the cycle before, at and after a completion edge
  task automatic conv_check(string req, int unsigned done_at, logic [9:0] s, logic busy_after);
    logic [7:0] v;
    wait_to(done_at - 1);
    rd(2'd0, v);
    chk({req, " busy before end"}, v[7], 1);
    chk({req, " no irq before end"}, irq_o, 0);
    wait_to(done_at);
    chk({req, " R12 irq at end"}, irq_o, 1);
    rd(2'd0, v);
    chk({req, " R7 busy after end"}, v[7], busy_after);
    rd(2'd1, v);
    chk({req, " R6 data high"}, v, exp_hi(s));
    rd(2'd2, v);
    chk({req, " R6 data low"}, v, exp_lo(s));
    wait_to(done_at + 1);
    chk({req, " R12 irq one cycle"}, irq_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    summary();
  end

  initial begin
    logic [7:0] v;
    int unsigned e0, done, ec;
    logic [9:0] s;
    void'($urandom(32'h5EED1234));

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #0.5;
    // R1 reset state
    chk("R1 pwr_down", pwr_down_o, 1);
    chk("R1 irq", irq_o, 0);
    rd(2'd0, v); chk("R1 ctrl", v, 0);
    rd(2'd1, v); chk("R1 data high", v, 0);
    rd(2'd2, v); chk("R1 data low", v, 0);

    // R5 start from powered-down, R2 field layout
    s = 10'h2D6;
    sample_in = s;
    wr(8'hA5, e0);
    chk("R5 pwr_down falls", pwr_down_o, 0);
    rd(2'd0, v);
    chk("R2 ctrl readback", v, 8'hA5);
    chk("R2 chan_o", chan_o, 5);
    chk("R2 ref_en_o", ref_en_o, 1);
    done = e0 + WAKE + CONV;
    conv_check("R5 wake+conv", done, s, 1'b0);
    ec = done;

    // R4 start from powered idle, R10 second start ignored
    s = 10'h13B;
    sample_in = s;
    wr(8'h83, e0);
    rd(2'd0, v);
    chk("R4 busy next cycle", v[7], 1);
    chk("R4 still powered", pwr_down_o, 0);
    wait_to(e0 + 100);
    wr(8'h83, done);
    done = e0 + CONV;
    conv_check("R10 R4 unchanged timing", done, s, 1'b0);
    ec = done;

    // R11 boundary: start on the 160th idle edge needs no wake-up
    s = 10'h3FF;
    sample_in = s;
    wait_to(ec + IDLE - 1);
    wr(8'h87, e0);
    chk("R11 boundary edge", e0, ec + IDLE);
    chk("R11 boundary still powered", pwr_down_o, 0);
    done = e0 + CONV;
    conv_check("R11 R4 no wake", done, s, 1'b0);
    ec = done;

    // R11 idle timeout
    wait_to(ec + IDLE - 1);
    chk("R11 powered at 159", pwr_down_o, 0);
    wait_to(ec + IDLE);
    chk("R11 down at 160", pwr_down_o, 1);

    // R3 invalid channel codes ignored, other fields written; R5 no wake without start
    wr(8'h2E, e0);
    chk("R3 chan kept", chan_o, 7);
    chk("R3 ref written", ref_en_o, 1);
    rd(2'd0, v);
    chk("R3 ctrl view", v, 8'h27);
    chk("R5 no wake without start", pwr_down_o, 1);
    wr(8'h0B, e0);
    chk("R3 code 11 stored", chan_o, 11);
    chk("R3 ref cleared", ref_en_o, 0);
    wr(8'h0C, e0);
    chk("R3 code 12 rejected", chan_o, 11);

    // R8 continuous mode, R9 stop request
    s = 10'h155;
    sample_in = s;
    wr(8'h92, e0);
    done = e0 + WAKE + CONV;
    conv_check("R8 first", done, s, 1'b1);
    s = 10'h2AA;
    sample_in = s;
    done = done + CONV;
    conv_check("R8 second", done, s, 1'b1);
    s = 10'h0C3;
    sample_in = s;
    wait_to(done + 50);
    wr(8'h12, e0);
    rd(2'd0, v);
    chk("R9 still busy after stop", v[7], 1);
    done = done + CONV;
    conv_check("R9 last", done, s, 1'b0);
    sample_in = 10'h001;
    wait_to(done + CONV + 1);
    rd(2'd0, v);
    chk("R9 no further conversion", v[7], 0);
    rd(2'd1, v);
    chk("R9 data kept", v, exp_hi(s));
    ec = done;

    // random single shots with random idle gaps
    for (int i = 0; i < 4; i++) begin
      int unsigned gap;
      logic [3:0] ch;
      gap = 2 + ($urandom % 320);
      ch  = 4'($urandom % 12);
      s   = 10'($urandom);
      sample_in = s;
      wait_to(ec + gap);
      wr({2'b10, 2'b00, ch}, e0);
      chk("R2 random chan", chan_o, ch);
      done = e0 + CONV + (((e0 - ec) > IDLE) ? WAKE : 0);
      conv_check("R4 R5 R6 random", done, s, 1'b0);
      ec = done;
    end

    summary();
  end
endmodule